// File: doc/BRIEF.md
# Receive-Only Serial Byte Link for a Display Driver

This block is the host-facing input port of a display driver. A host drives four wires into it: an active-low select, a serial clock, a serial data bit and a command/data flag. There is no wire back to the host. All four wires are brought into the system clock domain through synchronisers. The rising edges of the serial clock are then found by comparing the synchronised level against its value one cycle earlier.

The data line is captured on each rising serial clock edge, most significant bit first. On the eighth edge the block presents three things for one system cycle: the assembled byte, the command/data flag sampled on that same edge, and a valid strobe. If the select stays low, the next rising edge starts a new byte, so the host can stream bytes back to back. While the select is high the receiver is held cleared. An active-low asynchronous reset aborts any byte in progress and clears every register. The system clock must run at least four times faster than the serial clock.

Top module: `disp_serial_rx`

## Requirements
- R1: While rst_ni is low and after it is released, byte_o is 0, is_data_o is 0 and valid_o is 0 until a byte completes.
- R2: Serial bits are taken on rising sclk_i edges while cs_ni is low, and the first bit becomes byte_o[7] (MSB first).
- R3: The command/data flag is taken only at the eighth rising edge of a byte, and its level during the first seven edges has no effect.
- R4: A flag level of 0 on dc_i marks a command (is_data_o = 0), and a level of 1 marks display data (is_data_o = 1).
- R5: valid_o is high for exactly one system clock cycle per byte. byte_o and is_data_o are updated in that cycle and hold their values until the next byte completes.
- R6: With cs_ni held low, the rising edge after a byte's eighth edge is the MSB of the next byte, and bytes stream without toggling cs_ni.
- R7: Raising cs_ni in the middle of a byte discards the partial bits without a strobe, and the next byte starts fresh at its MSB.
- R8: sclk_i edges while cs_ni is high produce no strobe.
- R9: Asserting rst_ni mid-byte aborts the byte: no strobe is issued and the partial bits are lost.
- R10: If cs_ni is already low when rst_ni is released, a byte can be received with no toggle of cs_ni.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Link select, active low; high holds the receiver cleared |
| sclk_i | input | 1 | Serial clock from the host |
| sdin_i | input | 1 | Serial data, MSB first |
| dc_i | input | 1 | Command (0) or display data (1) flag |
| byte_o | output | 8 | Last received byte |
| is_data_o | output | 1 | Flag of the last received byte |
| valid_o | output | 1 | One-cycle strobe for a completed byte |

## Verification
The bench builds the block with its default parameters: an 8-bit byte and two synchroniser stages. It runs the serial clock at one eighth of the system rate. That ratio leaves room for the synchroniser delay while still letting one scenario stream several bytes back to back across the byte boundary. It also lets a select rise or a reset land after a chosen bit count within a byte.

// File: rtl/disp_rx_pkg.sv
package disp_rx_pkg;
  parameter int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              is_data;
    logic [BYTE_W-1:0] payload;
  } rx_word_t;

  // pin order inside the synchroniser bus
  localparam int unsigned PIN_CS   = 3;
  localparam int unsigned PIN_SCLK = 2;
  localparam int unsigned PIN_SDIN = 1;
  localparam int unsigned PIN_DC   = 0;
  localparam int unsigned NUM_PINS = 4;
endpackage

// File: rtl/disp_rx_sync.sv
module disp_rx_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else if (STAGES == 1) chain_q <= d_i[b];
      else chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/disp_rx_edge.sv
module disp_rx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/disp_rx_shift.sv
module disp_rx_shift
  import disp_rx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     idle_i,
  input  logic     rise_i,
  input  logic     bit_i,
  input  logic     dc_i,
  output rx_word_t word_o,
  output logic     valid_o
);
  localparam int unsigned CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] sh_next;

  assign sh_next = {sh_q[BYTE_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (idle_i) begin
        cnt_q <= '0;
        sh_q  <= '0;
      end else if (rise_i) begin
        sh_q <= sh_next;
        if (cnt_q == LAST) begin
          cnt_q          <= '0;
          word_o.payload <= sh_next;
          word_o.is_data <= dc_i;  // flag taken on the last edge only
          valid_o        <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R5
  valid_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R8
  idle_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |=> !valid_o);

  // R2
  valid_after_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(rise_i));

  // R5
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> valid_o);
endmodule

// File: rtl/disp_serial_rx.sv
module disp_serial_rx
  import disp_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdin_i,
  input  logic              dc_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              is_data_o,
  output logic              valid_o
);
  logic [NUM_PINS-1:0] pins_raw, pins_s;
  logic                sclk_rise;
  rx_word_t            word;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_CS]   = cs_ni;
    pins_raw[PIN_SCLK] = sclk_i;
    pins_raw[PIN_SDIN] = sdin_i;
    pins_raw[PIN_DC]   = dc_i;
  end

  disp_rx_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(NUM_PINS'(1) << PIN_CS)
  ) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  disp_rx_edge edge_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pins_s[PIN_SCLK]),
    .rise_o(sclk_rise)
  );

  disp_rx_shift shift_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idle_i (pins_s[PIN_CS]),
    .rise_i (sclk_rise),
    .bit_i  (pins_s[PIN_SDIN]),
    .dc_i   (pins_s[PIN_DC]),
    .word_o (word),
    .valid_o(valid_o)
  );

  assign byte_o    = word.payload;
  assign is_data_o = word.is_data;

  // R6
  no_double_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise |=> !sclk_rise);
endmodule

// File: tb/disp_serial_rx_tb_top.sv
module disp_serial_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdin = 1'b0, dc = 1'b0;
  logic [7:0] byte_o;
  logic is_data, valid;

  int n_chk = 0, n_fail = 0;
  int cap_n = 0, width_err = 0;
  logic [7:0] cap_b[0:31];
  logic       cap_d[0:31];
  logic       prev_v = 1'b0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  disp_serial_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk),
    .sdin_i(sdin), .dc_i(dc), .byte_o(byte_o), .is_data_o(is_data),
    .valid_o(valid)
  );

  always @(negedge clk) begin
    if (valid && prev_v) width_err++;
    if (valid && cap_n < 32) begin
      cap_b[cap_n] = byte_o;
      cap_d[cap_n] = is_data;
      cap_n++;
    end
    prev_v = valid;
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b, logic d);
    sdin = b; dc = d;
    cyc(4); sclk = 1'b1;
    cyc(4); sclk = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] v, logic d_last, logic d_early);
    for (int i = 7; i >= 0; i--) send_bit(v[i], (i == 0) ? d_last : d_early);
  endtask

  task automatic t_reset;
    chk("R1 byte", byte_o, 0);
    chk("R1 flag", is_data, 0);
    chk("R1 valid", valid, 0);
  endtask

  task automatic t_single;
    int n0 = cap_n;
    send_byte(8'hA5, 1'b1, 1'b1); cyc(8);
    chk("R2 count", cap_n - n0, 1);
    chk("R2 byte", cap_b[n0], 8'hA5);
    chk("R4 data flag", cap_d[n0], 1);
    cyc(20);
    chk("R5 hold byte", byte_o, 8'hA5);
    chk("R5 width", width_err, 0);
  endtask

  task automatic t_cmd;
    int n0 = cap_n;
    send_byte(8'h3C, 1'b0, 1'b1); cyc(8);
    chk("R3 count", cap_n - n0, 1);
    chk("R3 byte", cap_b[n0], 8'h3C);
    chk("R3 R4 cmd flag", cap_d[n0], 0);
  endtask

  task automatic t_stream;
    int n0 = cap_n;
    send_byte(8'h01, 1'b1, 1'b0);
    send_byte(8'h80, 1'b0, 1'b1);
    send_byte(8'hFF, 1'b1, 1'b0);
    cyc(8);
    chk("R6 count", cap_n - n0, 3);
    chk("R6 b0", cap_b[n0], 8'h01);
    chk("R6 b1", cap_b[n0+1], 8'h80);
    chk("R6 b2", cap_b[n0+2], 8'hFF);
    chk("R6 flags", {cap_d[n0], cap_d[n0+1], cap_d[n0+2]}, 3'b101);
    chk("R5 width", width_err, 0);
  endtask

  task automatic t_cs_abort;
    int n0 = cap_n;
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b1);
    cs_n = 1'b1; cyc(8);
    chk("R7 no strobe", cap_n - n0, 0);
    cs_n = 1'b0; cyc(8);
    send_byte(8'h5A, 1'b0, 1'b0); cyc(8);
    chk("R7 count", cap_n - n0, 1);
    chk("R7 fresh byte", cap_b[n0], 8'h5A);
  endtask

  task automatic t_cs_high;
    int n0 = cap_n;
    cs_n = 1'b1; cyc(8);
    for (int i = 0; i < 16; i++) send_bit(i[0], 1'b1);
    cyc(8);
    chk("R8 no strobe", cap_n - n0, 0);
    chk("R8 byte kept", byte_o, 8'h5A);
    cs_n = 1'b0; cyc(8);
  endtask

  task automatic t_async_reset;
    int n0 = cap_n;
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b1);
    rst_n = 1'b0; cyc(3);
    chk("R9 byte cleared", byte_o, 0);
    chk("R9 valid low", valid, 0);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b1);
    chk("R9 no strobe", cap_n - n0, 0);
    rst_n = 1'b1; cyc(4);
    send_byte(8'hC3, 1'b1, 1'b0); cyc(8);
    chk("R10 count", cap_n - n0, 1);
    chk("R10 byte", cap_b[n0], 8'hC3);
    chk("R10 flag", cap_d[n0], 1);
  endtask

  initial begin
    cyc(5);
    t_reset;
    rst_n = 1'b1; cyc(5);
    t_reset;
    cs_n = 1'b0; cyc(6);
    t_single;
    t_cmd;
    t_stream;
    t_cs_abort;
    t_cs_high;
    t_async_reset;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule